// File: doc/BRIEF.md
# Real-Time Clock Hour Counter with 12/24-Hour Modes

This block holds the hours field of a real-time clock as a BCD byte and steps it forward whenever the minute stage signals a roll past minute 59. It has two counting modes. The 24-hour mode counts plainly from 00h to 23h. The 12-hour mode carries an afternoon flag in bit 5 of the same byte. Because of that flag, the count follows a broken path: 12h for midnight, then 01h to 11h, then 32h for noon, then 21h to 31h, and back to 12h.

A host can load the hour byte directly. It can also write an 8-bit control byte. That byte holds the mode select, the enables for the weekly and daily alarms, and five further bits that are only stored and read back. Each time the hour wraps back to midnight, a one-cycle day-carry pulse goes out to the day counter.

Software is expected to choose the mode before loading any time value. The block does not convert the stored hour when the mode changes.

Top module: `rtc_hour_top`

## Requirements
- R1: In the clock cycle after reset is held high, the hour byte reads 12h, the control byte reads 00h (12-hour mode, both alarm enables off), and the day-carry output is 0.
- R2: A control write stores all eight bits, and they read back on the next cycle. Bit 7 is the weekly alarm enable. Bit 6 is the daily alarm enable. Bit 5 selects the mode (0 = 12-hour, 1 = 24-hour). Bits 4..0 are stored only.
- R3: When no advance pulse and no hour write occur in a cycle, the hour byte keeps its value.
- R4: In 24-hour mode, each advance steps the hour in BCD through 00h..23h. An advance from 23h, or from any greater value, gives 00h.
- R5: In 12-hour mode, advances follow 12h, 01h..11h, 32h, 21h..31h, and 31h returns to 12h. Bit 5 set marks the afternoon.
- R6: The day-carry output is high for exactly one cycle, in the same cycle that a wrap to midnight appears. A wrap to midnight is 23h (or above) to 00h in 24-hour mode, or 31h to 12h in 12-hour mode. The output is low at all other times.
- R7: An hour write in the same cycle as an advance wins. The written byte appears on the next cycle and no day carry is raised.
- R8: Changing the mode bit leaves the stored hour as it is. The next advance applies the rules of the new mode to that stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | One-cycle hour-advance pulse from the minute stage |
| hour_we_i | input | 1 | Hour byte write strobe |
| hour_wdata_i | input | 8 | Hour byte write data (BCD, bit 5 = PM in 12-hour mode) |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| hour_o | output | 8 | Current hour byte |
| ctrl_o | output | 8 | Control byte readback |
| day_carry_o | output | 1 | One-cycle pulse on wrap to midnight |

## Verification
The bench targets the edges of the 12-hour path, where each kind of error shows up in a distinct way:
- Stepping 11h to 12h instead of to 32h, or 12h to 13h instead of to 01h, means the ordinary BCD step leaked into the 12-hour path.
- Stepping 31h to 32h, or raising no carry there, means the midnight wrap was missed.
- Stepping 09h to 0Ah means the BCD digit carry is missing.

The bench also drives a write and an advance in the same cycle. A design with the priority reversed would show the stepped value or a stray carry. Finally, the bench switches modes over a stored value such as 32h. A design that converted the hour on a mode change would produce a value other than 00h on the next advance.

// File: rtl/rtc_hour_pkg.sv
package rtc_hour_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam logic [BYTE_W-1:0] MIDNIGHT_12 = 8'h12;
    localparam logic [BYTE_W-1:0] LAST_24     = 8'h23;
    localparam int PM_BIT   = 5;

    typedef struct packed {
        logic       wk_alm_en;
        logic       dy_alm_en;
        logic       mode24;
        logic [4:0] spare;
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hour;
        logic              wrap;
    } step_t;

    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
        hi = v[BYTE_W-1:NIB_W];
        lo = v[NIB_W-1:0];
        if (lo >= 4'd9) begin
            return {hi + 4'd1, 4'd0};
        end
        return {hi, lo + 4'd1};
    endfunction

    function automatic step_t step_24(input logic [BYTE_W-1:0] h);
        step_t s;
        if (h >= LAST_24) begin
            s.hour = '0;
            s.wrap = 1'b1;
        end else begin
            s.hour = bcd_inc(h);
            s.wrap = 1'b0;
        end
        return s;
    endfunction

    function automatic step_t step_12(input logic [BYTE_W-1:0] h);
        step_t            s;
        logic             pm;
        logic [BYTE_W-1:0] base;
        pm   = h[PM_BIT];
        base = {3'b000, h[4:0]};
        s.wrap = 1'b0;
        if (base == 8'h12) begin
            s.hour = pm ? 8'h21 : 8'h01;
        end else if (base >= 8'h11) begin
            if (pm) begin
                s.hour = MIDNIGHT_12;
                s.wrap = 1'b1;
            end else begin
                s.hour = 8'h32;
            end
        end else begin
            s.hour = bcd_inc(base);
            s.hour[PM_BIT] = pm;
        end
        return s;
    endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_hour_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output ctrl_t        ctrl_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
        end else if (we_i) begin
            ctrl_o <= ctrl_t'(wdata_i);
        end
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_hour_pkg::*;
#(
    parameter bit HAS_12H = 1'b1
) (
    input  logic [BYTE_W-1:0] hour_i,
    input  logic              mode24_i,
    output step_t             step_o
);
    generate
        if (HAS_12H) begin : g_dual
            always_comb begin
                step_o = mode24_i ? step_24(hour_i) : step_12(hour_i);
            end
        end else begin : g_24only
            logic unused_mode;
            assign unused_mode = mode24_i;
            always_comb begin
                step_o = step_24(hour_i);
            end
        end
    endgenerate
endmodule

// File: rtl/rtc_hour_reg.sv
module rtc_hour_reg
    import rtc_hour_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_HOUR = MIDNIGHT_12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic              we_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  step_t             step_i,
    output logic [BYTE_W-1:0] hour_o,
    output logic              carry_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hour_o  <= RST_HOUR;
            carry_o <= 1'b0;
        end else if (we_i) begin
            hour_o  <= wdata_i;
            carry_o <= 1'b0;
        end else if (adv_i) begin
            hour_o  <= step_i.hour;
            carry_o <= step_i.wrap;
        end else begin
            carry_o <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_hour_top.sv
module rtc_hour_top
    import rtc_hour_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv_i,
    input  logic       hour_we_i,
    input  logic [7:0] hour_wdata_i,
    input  logic       ctrl_we_i,
    input  logic [7:0] ctrl_wdata_i,
    output logic [7:0] hour_o,
    output logic [7:0] ctrl_o,
    output logic       day_carry_o
);
    ctrl_t             ctrl_q;
    step_t             step_w;
    logic [BYTE_W-1:0] hour_q;

    rtc_ctrl_reg #(.W(BYTE_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we_i    (ctrl_we_i),
        .wdata_i (ctrl_wdata_i),
        .ctrl_o  (ctrl_q)
    );

    rtc_hour_step #(.HAS_12H(1'b1)) u_step (
        .hour_i   (hour_q),
        .mode24_i (ctrl_q.mode24),
        .step_o   (step_w)
    );

    rtc_hour_reg #(.RST_HOUR(MIDNIGHT_12)) u_hour (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv_i),
        .we_i    (hour_we_i),
        .wdata_i (hour_wdata_i),
        .step_i  (step_w),
        .hour_o  (hour_q),
        .carry_o (day_carry_o)
    );

    assign hour_o = hour_q;
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rtc_hour_checker.sv
module rtc_hour_checker (
    input logic       clk,
    input logic       rst,
    input logic       adv_i,
    input logic       hour_we_i,
    input logic [7:0] hour_wdata_i,
    input logic       ctrl_we_i,
    input logic [7:0] ctrl_wdata_i,
    input logic [7:0] hour_o,
    input logic [7:0] ctrl_o,
    input logic       day_carry_o
);
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we_i |=> ctrl_o == $past(ctrl_wdata_i));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !hour_we_i) |=> $stable(hour_o));

    assert_range_24_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o[5] && !ctrl_we_i && adv_i && !hour_we_i && hour_o <= 8'h23)
        |=> hour_o <= 8'h23);

    assert_carry_at_midnight_R6: assert property (@(posedge clk) disable iff (rst)
        day_carry_o |-> (hour_o == 8'h00 || hour_o == 8'h12));

    assert_carry_needs_adv_R6: assert property (@(posedge clk) disable iff (rst)
        day_carry_o |-> ($past(adv_i) && !$past(hour_we_i)));

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
        hour_we_i |=> (hour_o == $past(hour_wdata_i) && !day_carry_o));
endmodule

bind rtc_hour_top rtc_hour_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .adv_i        (adv_i),
    .hour_we_i    (hour_we_i),
    .hour_wdata_i (hour_wdata_i),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .hour_o       (hour_o),
    .ctrl_o       (ctrl_o),
    .day_carry_o  (day_carry_o)
);

// File: tb/rtc_hour_top_bench.sv
module rtc_hour_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_i = 1'b0;
    logic       hour_we_i = 1'b0;
    logic [7:0] hour_wdata_i = 8'h00;
    logic       ctrl_we_i = 1'b0;
    logic [7:0] ctrl_wdata_i = 8'h00;
    logic [7:0] hour_o;
    logic [7:0] ctrl_o;
    logic       day_carry_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] exp_hour;
    logic [7:0] exp_ctrl;
    logic       exp_carry;

    always #4 clk = ~clk;

    rtc_hour_top u_rtc_hour_top (
        .clk(clk), .rst(rst), .adv_i(adv_i), .hour_we_i(hour_we_i),
        .hour_wdata_i(hour_wdata_i), .ctrl_we_i(ctrl_we_i),
        .ctrl_wdata_i(ctrl_wdata_i), .hour_o(hour_o), .ctrl_o(ctrl_o),
        .day_carry_o(day_carry_o)
    );

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // advance model, via a 0..23 hour-of-day number
    function automatic logic [8:0] model_adv(input logic [7:0] h, input logic m24);
        int d;
        int v;
        logic [7:0] r;
        if (m24) begin
            d = from_bcd(h);
            if (d >= 23) return {8'h00, 1'b1};
            return {to_bcd(d + 1), 1'b0};
        end
        v = from_bcd({3'b000, h[4:0]});
        if (v == 12) v = 0;
        d = v + (h[5] ? 12 : 0);
        if (d == 23) return {8'h12, 1'b1};
        d = d + 1;
        v = d % 12;
        if (v == 0) v = 12;
        r = to_bcd(v);
        r[5] = (d >= 12);
        return {r, 1'b0};
    endfunction

    function automatic logic [7:0] valid_hour(input logic m24, input int pick);
        int d;
        logic [7:0] r;
        d = pick % 24;
        if (m24) return to_bcd(d);
        r = to_bcd((d % 12 == 0) ? 12 : d % 12);
        r[5] = (d >= 12);
        return r;
    endfunction

    task automatic check(input string req);
        n_cmp++;
        if (hour_o !== exp_hour || day_carry_o !== exp_carry || ctrl_o !== exp_ctrl) begin
            n_bad++;
            $display("FAIL %s: hour=%h carry=%b ctrl=%h expected hour=%h carry=%b ctrl=%h",
                     req, hour_o, day_carry_o, ctrl_o, exp_hour, exp_carry, exp_ctrl);
        end
    endtask

    // drive one cycle from a negedge; model the edge; check at next negedge
    task automatic cyc(input logic a, input logic hw, input logic [7:0] hd,
                       input logic cw, input logic [7:0] cd, input string req);
        logic [8:0] s;
        adv_i = a; hour_we_i = hw; hour_wdata_i = hd;
        ctrl_we_i = cw; ctrl_wdata_i = cd;
        s = model_adv(exp_hour, exp_ctrl[5]);
        exp_carry = 1'b0;
        if (hw) exp_hour = hd;
        else if (a) begin
            exp_hour = s[8:1];
            exp_carry = s[0];
        end
        if (cw) exp_ctrl = cd;
        @(negedge clk);
        check(req);
    endtask

    initial begin
        #1000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_hour = 8'h12; exp_ctrl = 8'h00; exp_carry = 1'b0;
        check("R1");

        // R2: every control bit stored and read back
        cyc(0, 0, 8'h00, 1, 8'hDF, "R2");
        cyc(0, 0, 8'h00, 1, 8'h00, "R2");
        // R3: idle cycles hold
        for (int i = 0; i < 3; i++) cyc(0, 0, 8'h00, 0, 8'h00, "R3");
        // R5: full 12-hour day from midnight, including 31h -> 12h carry (R6)
        for (int i = 0; i < 24; i++) cyc(1, 0, 8'h00, 0, 8'h00, "R5_R6");
        // R4: full 24-hour day
        cyc(0, 0, 8'h00, 1, 8'h20, "R2");
        cyc(0, 1, 8'h00, 0, 8'h00, "R7");
        for (int i = 0; i < 25; i++) cyc(1, 0, 8'h00, 0, 8'h00, "R4_R6");
        // R7: write and advance together at 23h
        cyc(0, 1, 8'h22, 0, 8'h00, "R7");
        cyc(1, 1, 8'h23, 0, 8'h00, "R7");
        cyc(1, 1, 8'h09, 0, 8'h00, "R7");
        cyc(1, 0, 8'h00, 0, 8'h00, "R4");
        // R8: switch to 12h over 08h then advance; store 32h, switch to 24h, advance
        cyc(0, 1, 8'h08, 1, 8'h00, "R8");
        cyc(1, 0, 8'h00, 0, 8'h00, "R8");
        cyc(0, 1, 8'h32, 0, 8'h00, "R8");
        cyc(0, 0, 8'h00, 1, 8'h20, "R8");
        cyc(1, 0, 8'h00, 0, 8'h00, "R8_R4");

        // random phases, mode fixed per phase, writes use valid encodings
        for (int ph = 0; ph < 6; ph++) begin
            logic [7:0] c;
            c = 8'($urandom);
            cyc(0, 1, valid_hour(c[5], int'($urandom % 24)), 1, c, "R2");
            for (int i = 0; i < 400; i++) begin
                logic a;
                logic w;
                a = ($urandom % 3) != 0;
                w = ($urandom % 16) == 0;
                cyc(a, w, valid_hour(c[5], int'($urandom % 24)), 0, 8'h00,
                    c[5] ? "R4_R6_R7" : "R5_R6_R7");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule